// File: doc/BRIEF.md
# Frame-Difference Motion Detector

This block watches a raster video stream and decides, once per frame, whether the scene has changed enough to be worth recording. For every active pixel it receives two 24-bit RGB values in the same cycle: the pixel just captured and the pixel at the same position in the preceding frame, read back from frame storage in lockstep. It sums the absolute per-channel differences. It marks the pixel as changed when that sum is above a per-pixel threshold, and it counts the changed pixels over the whole frame.

When the frame-valid qualifier drops, the block compares the changed-pixel count with a frame-level threshold. It emits a one-cycle motion trigger only if the count is strictly greater than that threshold and the external human-presence input is high at that moment. The count of the completed frame is also held on a status output until the next frame ends. The first frame after reset has no valid predecessor, so it never triggers.

Top module: `frame_motion_detector`

## Requirements
- R1: While reset is high and just after it, `motion_trig` is 0 and `change_count` is 0.
- R2: A pixel's difference is |ΔR|+|ΔG|+|ΔB|, taken over the channels in bits [23:16], [15:8] and [7:0] of the pixel words. The pixel counts as changed only when this sum is strictly greater than `pix_thresh`, so a sum equal to the threshold is not counted.
- R3: A pixel is used only in cycles where both `fval` and `lval` are high. Pixel data presented while either qualifier is low has no effect on `change_count`.
- R4: `change_count` shows the number of changed pixels in the most recently completed frame. It is updated on the second rising clock edge after the first cycle in which `fval` is sampled low, and it holds that value until the next frame ends.
- R5: `motion_trig` is high for exactly one cycle. It rises together with the `change_count` update of R4, and only when that count is strictly greater than `frame_thresh` and `presence` is high. It is never high while a frame is in progress.
- R6: No trigger occurs when the count equals `frame_thresh`, or when `presence` is low at the decision edge.
- R7: The first frame that completes after reset never produces a trigger, whatever its count.
- R8: The changed-pixel count restarts at the start of every frame, so a frame's result does not include pixels from earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fval | input | 1 | Frame-valid qualifier |
| lval | input | 1 | Line-valid qualifier |
| cur_pix | input | 24 | Current-frame pixel, R in [23:16], G in [15:8], B in [7:0] |
| prev_pix | input | 24 | Same-position pixel of the previous frame, same layout |
| pix_thresh | input | 10 | Per-pixel change threshold on the summed channel difference |
| frame_thresh | input | 19 (CNT_W) | Changed-pixel count that must be exceeded to signal motion |
| presence | input | 1 | Human-presence sensor level |
| motion_trig | output | 1 | One-cycle motion event at frame end |
| change_count | output | 19 (CNT_W) | Changed-pixel count of the last completed frame |

## Verification
A wrong internal state almost always appears at the next frame end. An accumulator that is not cleared, or that counts blanking data, shows up as a wrong `change_count` two cycles after `fval` falls. A wrong reading of the qualifier edge shows up as a trigger that fires mid-frame, lasts more than one cycle, or arrives in the wrong cycle. A lost "previous frame exists" flag shows up either as a trigger on the first frame after reset or as a missing trigger on a later frame. The frames are therefore built so that their changed-pixel counts sit on either side of the threshold and exactly on it. Every frame also carries blanking data that would change the count if it were accepted.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;
    localparam int DIFF_W = CH_W + 2;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic changed;
        logic fval;
    } diff_beat_t;

    function automatic logic [CH_W-1:0] chan_absdiff(input logic [CH_W-1:0] a,
                                                     input logic [CH_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    function automatic logic [DIFF_W-1:0] rgb_sad(input rgb_t a, input rgb_t b);
        logic [DIFF_W-1:0] acc;
        acc = DIFF_W'(chan_absdiff(a.r, b.r));
        acc = acc + DIFF_W'(chan_absdiff(a.g, b.g));
        acc = acc + DIFF_W'(chan_absdiff(a.b, b.b));
        return acc;
    endfunction

endpackage

// File: rtl/fmd_pix_diff.sv
module fmd_pix_diff
    import fmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fval,
    input  logic              lval,
    input  rgb_t              cur,
    input  rgb_t              prev,
    input  logic [DIFF_W-1:0] thr,
    output diff_beat_t        beat
);

    logic              take;
    logic [DIFF_W-1:0] sad;

    always_comb begin
        take = fval & lval;
        sad  = rgb_sad(cur, prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid   <= take;
            beat.changed <= take & (sad > thr);
            beat.fval    <= fval;
        end
    end

    AST_BEAT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        beat.valid |-> $past(fval && lval)); // R3
    AST_CHANGED_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        beat.changed |-> beat.valid); // R3

endmodule

// File: rtl/fmd_accum.sv
module fmd_accum
    import fmd_pkg::*;
#(
    parameter int MAX_PIX = 640 * 480,
    parameter int CNT_W   = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  diff_beat_t       beat,
    output logic [CNT_W-1:0] count,
    output logic             frame_end
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PIX);

    logic fval_prev;
    logic frame_start;
    logic hit;

    always_comb begin
        frame_start = beat.fval & ~fval_prev;
        frame_end   = ~beat.fval & fval_prev;
        hit         = beat.valid & beat.changed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fval_prev <= 1'b0;
            count     <= '0;
        end else begin
            fval_prev <= beat.fval;
            if (frame_start) begin
                count <= hit ? CNT_W'(1) : '0;
            end else if (hit && (count != CNT_MAX)) begin
                count <= count + 1'b1;
            end
        end
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!beat.valid && !frame_start) |=> $stable(count)); // R3

endmodule

// File: rtl/fmd_decide.sv
module fmd_decide #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] frame_thr,
    input  logic             presence,
    output logic             trig,
    output logic [CNT_W-1:0] stat_count
);

    logic have_prev;
    logic fire;

    always_comb begin
        fire = frame_end & have_prev & presence & (count > frame_thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig       <= 1'b0;
            stat_count <= '0;
            have_prev  <= 1'b0;
        end else begin
            trig <= fire;
            if (frame_end) begin
                stat_count <= count;
                have_prev  <= 1'b1;
            end
        end
    end

    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig); // R5
    AST_TRIG_AT_END: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(frame_end)); // R5
    AST_TRIG_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
        trig |-> (stat_count > $past(frame_thr))); // R6
    AST_TRIG_PRESENCE: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(presence)); // R6

endmodule

// File: rtl/frame_motion_detector.sv
module frame_motion_detector
    import fmd_pkg::*;
#(
    parameter int H_PIX   = 640,
    parameter int V_LINES = 480,
    parameter int CNT_W   = $clog2(H_PIX * V_LINES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fval,
    input  logic                lval,
    input  logic [PIX_W-1:0]    cur_pix,
    input  logic [PIX_W-1:0]    prev_pix,
    input  logic [DIFF_W-1:0]   pix_thresh,
    input  logic [CNT_W-1:0]    frame_thresh,
    input  logic                presence,
    output logic                motion_trig,
    output logic [CNT_W-1:0]    change_count
);

    localparam int FRAME_PIX = H_PIX * V_LINES;

    rgb_t             cur_rgb;
    rgb_t             prev_rgb;
    diff_beat_t       beat;
    logic [CNT_W-1:0] run_count;
    logic             frame_end;

    always_comb begin
        cur_rgb  = rgb_t'(cur_pix);
        prev_rgb = rgb_t'(prev_pix);
    end

    fmd_pix_diff u_diff (
        .clk  (clk),
        .rst  (rst),
        .fval (fval),
        .lval (lval),
        .cur  (cur_rgb),
        .prev (prev_rgb),
        .thr  (pix_thresh),
        .beat (beat)
    );

    fmd_accum #(
        .MAX_PIX (FRAME_PIX),
        .CNT_W   (CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .count     (run_count),
        .frame_end (frame_end)
    );

    fmd_decide #(
        .CNT_W (CNT_W)
    ) u_decide (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .count      (run_count),
        .frame_thr  (frame_thresh),
        .presence   (presence),
        .trig       (motion_trig),
        .stat_count (change_count)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!motion_trig && change_count == '0)); // R1

endmodule

// File: tb/frame_motion_detector_tb.sv
module frame_motion_detector_tb;

    localparam int H  = 8;
    localparam int V  = 4;
    localparam int CW = $clog2(H * V + 1);
    localparam int PT = 20;
    localparam int NV = 8;

    // per frame: changed pixels, presence, frame threshold, direction, expected trigger
    localparam int V_NCHG [NV] = '{32, 10, 10, 10, 0, 1, 32, 5};
    localparam int V_PRES [NV] = '{ 1,  1,  1,  0, 1, 1,  1, 1};
    localparam int V_FTHR [NV] = '{ 0,  9, 10,  5, 0, 0, 31, 20};
    localparam int V_DIR  [NV] = '{ 0,  0,  1,  0, 1, 0,  1, 0};
    localparam int V_TRIG [NV] = '{ 0,  1,  0,  0, 0, 1,  1, 0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fval = 1'b0;
    logic          lval = 1'b0;
    logic [23:0]   cur_pix = '0;
    logic [23:0]   prev_pix = '0;
    logic [9:0]    pix_thresh = 10'(PT);
    logic [CW-1:0] frame_thresh = '0;
    logic          presence = 1'b0;
    logic          motion_trig;
    logic [CW-1:0] change_count;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  in_frame = 1'b0;
    bit  trig_mid = 1'b0;

    always #5 clk = ~clk;

    frame_motion_detector #(.H_PIX(H), .V_LINES(V)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .fval         (fval),
        .lval         (lval),
        .cur_pix      (cur_pix),
        .prev_pix     (prev_pix),
        .pix_thresh   (pix_thresh),
        .frame_thresh (frame_thresh),
        .presence     (presence),
        .motion_trig  (motion_trig),
        .change_count (change_count)
    );

    always @(negedge clk) if (in_frame && motion_trig) trig_mid = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pix(input int idx, input bit chg, input int dir);
        logic [7:0] r0, g0, b0;
        r0 = 8'(100 + idx);
        g0 = 8'(120 + idx);
        b0 = 8'(90 + idx);
        prev_pix = {r0, g0, b0};
        // changed: 10+6+5 = 21 > 20; unchanged: 10+5+5 = 20, not counted (R2)
        if (dir == 0)
            cur_pix = {r0 + 8'd10, g0 - (chg ? 8'd6 : 8'd5), b0 + 8'd5};
        else
            cur_pix = {r0 - 8'd10, g0 + (chg ? 8'd6 : 8'd5), b0 - 8'd5};
    endtask

    task automatic drive_frame(input int nchg, input int dir);
        @(negedge clk);
        fval = 1'b1; lval = 1'b0;
        cur_pix = 24'hFFFFFF; prev_pix = 24'h000000;
        in_frame = 1'b1;
        for (int row = 0; row < V; row++) begin
            for (int col = 0; col < H; col++) begin
                @(negedge clk);
                lval = 1'b1;
                set_pix(row * H + col, (row * H + col) < nchg, dir);
            end
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                lval = 1'b0;
                cur_pix = 24'hFFFFFF; prev_pix = 24'h000000; // blanking garbage, R3
            end
        end
        @(negedge clk);
        fval = 1'b0; lval = 1'b1;   // line-valid alone must be ignored, R3
        cur_pix = 24'hFFFFFF; prev_pix = 24'h000000;
        @(posedge clk);
        in_frame = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(motion_trig == 1'b0, "R1 trig in reset", int'(motion_trig), 0);
        check(change_count == '0, "R1 count in reset", int'(change_count), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            presence     = V_PRES[v][0];
            frame_thresh = CW'(V_FTHR[v]);
            drive_frame(V_NCHG[v], V_DIR[v]);
            // R4 / R8 count of this frame only; R2 boundary; R3 blanking ignored
            check(int'(change_count) == V_NCHG[v], "R4 R8 frame count",
                  int'(change_count), V_NCHG[v]);
            // R5 / R6 / R7 decision
            check(int'(motion_trig) == V_TRIG[v], (v == 0) ? "R7 first frame" : "R5 R6 trigger",
                  int'(motion_trig), V_TRIG[v]);
            @(posedge clk);
            #1;
            check(motion_trig == 1'b0, "R5 single cycle", int'(motion_trig), 0);
            check(int'(change_count) == V_NCHG[v], "R4 count held",
                  int'(change_count), V_NCHG[v]);
            @(negedge clk);
            lval = 1'b0;
            repeat (3) @(negedge clk);
        end

        check(trig_mid == 1'b0, "R5 no trigger mid-frame", int'(trig_mid), 0);

        // reset mid-run: outputs clear, next frame is again a first frame
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(motion_trig == 1'b0 && change_count == '0, "R1 reset mid-run",
              int'(change_count), 0);
        @(negedge clk);
        rst = 1'b0;
        presence = 1'b1;
        frame_thresh = '0;
        drive_frame(20, 0);
        check(motion_trig == 1'b0, "R7 first frame after reset", int'(motion_trig), 0);
        check(int'(change_count) == 20, "R2 count after reset", int'(change_count), 20);
        @(negedge clk);
        lval = 1'b0;
        repeat (3) @(negedge clk);
        drive_frame(20, 1);
        check(motion_trig == 1'b1, "R5 second frame after reset", int'(motion_trig), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule